// File: doc/BRIEF.md
# Mode-Selectable Phase Accumulator Counter

This block is a counter peripheral built around a phase accumulator. On each system clock the accumulator can add a frequency word to itself. A 5-bit mode code chooses the rule for the add. It can add on every clock, add only while a selected input pin is high, or add only when a chosen Boolean function of two selected input pins is true. The same mode code chooses what the block drives onto its output pins: the accumulator's top bit, the carry from the most recent add, or nothing.

Software can write the frequency word and the accumulator at any time, and it can read the accumulator. The mode code and two pin-select values set how the block is used:
- As an oscillator, by driving the accumulator MSB onto the A pin.
- As a pulse generator, by driving one-clock carry pulses onto the A pin.
- As a level detector or edge-gated counter on pins A and B.

The differential output variants also drive pin B with the inverse of pin A.

Top module: `phase_acc_counter`

## Requirements
- R1: Mode 5'b00000, and every code not named in R2, R3, R5 or R6, disables the counter. The accumulator holds its value and every bit of `pin_drive` is low.
- R2: In the oscillator modes (5'b00100 single-ended, 5'b00101 differential), the accumulator adds the frequency word on every clock. Pin A (`pin_drive[sel_a]`) is driven with accumulator bit 31.
- R3: In the pulse modes (5'b00110 single-ended, 5'b00111 differential), the accumulator adds on every clock. Pin A is high for exactly the one cycle after an add that overflowed, and low otherwise.
- R4: In pulse mode with frequency word 2^30 and the accumulator started at 0, pin A pulses once every 4 clocks. The first pulse follows the fourth add.
- R5: Mode 5'b01000 adds the frequency word only on clocks where the registered level of pin A is high. Pin A held high for 4 sampled clocks gives exactly 4 adds. No pin is driven in this mode.
- R6: Modes 5'b1TTTT add only when bit {A,B} of the truth table TTTT is 1, where A is the index MSB. For example, 5'b11000 adds only when both A and B are high. No pin is driven in these modes.
- R7: In the differential variants, pin B is driven with the inverse of pin A. If `sel_a` equals `sel_b`, pin A's value wins. Unselected pins are low.
- R8: A frequency-word write in a cycle that also adds takes effect from the next cycle. The add in progress uses the whole old word.
- R9: An accumulator write takes priority over any add in that cycle. It also clears the pending carry pulse.
- R10: Pin inputs pass through one register stage. A gating decision at a clock edge uses the pin levels captured at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 5 | Function select code |
| sel_a | input | 3 | Index of pin A |
| sel_b | input | 3 | Index of pin B |
| pins_in | input | 8 | Raw input pin levels |
| frq_wr | input | 1 | Frequency word write strobe |
| frq_wdata | input | 32 | Frequency word write data |
| phs_wr | input | 1 | Accumulator write strobe |
| phs_wdata | input | 32 | Accumulator write data |
| pin_drive | output | 8 | Output pin levels |
| phs_rd | output | 32 | Accumulator value |

## Verification
The bench targets four corner cases.

- **Pin-input latency.** A pin rises and the accumulator is read one and two clocks later. A design without the input register would count one clock early.
- **Frequency-word write during an add.** The bench writes a new frequency word in the same cycle as an add. A design that forwards the new word would show the wrong sum in that cycle.
- **Accumulator write during an add.** The bench writes the accumulator while the counter is accumulating. A design that lets the add win would lose the written value.
- **Pulse-mode overflow spacing.** Pulse spacing is counted at 2^30. A combinational or stretched carry would produce pulses that are wider than one clock or spaced wrongly.

All 16 logic truth tables are also swept under every pin combination. A swapped A/B index order shows up there as wrong counts.

// File: rtl/pac_pkg.sv
// Package for the phase accumulator counter: mode codes and the
// decoded control record shared by the decoder, driver and top.
package pac_pkg;

    localparam logic [4:0] MODE_OFF       = 5'b00000;
    localparam logic [4:0] MODE_NCO       = 5'b00100;
    localparam logic [4:0] MODE_NCO_DIFF  = 5'b00101;
    localparam logic [4:0] MODE_DUTY      = 5'b00110;
    localparam logic [4:0] MODE_DUTY_DIFF = 5'b00111;
    localparam logic [4:0] MODE_POSDET    = 5'b01000;

    // Source of the value placed on pin A
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_MSB   = 2'd1,
        SRC_CARRY = 2'd2
    } out_src_e;

    // Decoded per-mode control
    typedef struct packed {
        logic       add_always;
        logic       add_det;
        logic       add_logic;
        logic [3:0] truth;
        out_src_e   src;
        logic       diff;
    } ctl_t;

endpackage

// File: rtl/pac_pin_sampler.sv
// Input register for all pins followed by the A/B select muxes.
// Assumes sel_a/sel_b are below NPINS; the mux sits after the flop,
// so a select change applies at once to already-registered levels.
module pac_pin_sampler #(
    parameter int NPINS = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_in,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    output logic             a_lvl,
    output logic             b_lvl
);

    logic [NPINS-1:0] pins_q;

    // Capture every raw pin level once per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= '0;
        end else begin
            pins_q <= pins_in;
        end
    end

    // Pick the two registered levels named by the selects
    always_comb begin
        a_lvl = pins_q[sel_a];
        b_lvl = pins_q[sel_b];
    end

endmodule

// File: rtl/pac_mode_decode.sv
// Turns the 5-bit mode code into add-gating and output controls.
// Codes with the MSB set are logic modes whose low nibble is a
// truth table; unlisted codes decode to the disabled state.
module pac_mode_decode
    import pac_pkg::*;
(
    input  logic [4:0] mode,
    output ctl_t       ctl
);

    // Combinational decode of the mode field
    always_comb begin
        ctl.add_always = 1'b0;
        ctl.add_det    = 1'b0;
        ctl.add_logic  = 1'b0;
        ctl.truth      = 4'b0000;
        ctl.src        = SRC_NONE;
        ctl.diff       = 1'b0;
        if (mode[4]) begin
            ctl.add_logic = 1'b1;
            ctl.truth     = mode[3:0];
        end else begin
            case (mode)
                MODE_NCO: begin
                    ctl.add_always = 1'b1;
                    ctl.src        = SRC_MSB;
                end
                MODE_NCO_DIFF: begin
                    ctl.add_always = 1'b1;
                    ctl.src        = SRC_MSB;
                    ctl.diff       = 1'b1;
                end
                MODE_DUTY: begin
                    ctl.add_always = 1'b1;
                    ctl.src        = SRC_CARRY;
                end
                MODE_DUTY_DIFF: begin
                    ctl.add_always = 1'b1;
                    ctl.src        = SRC_CARRY;
                    ctl.diff       = 1'b1;
                end
                MODE_POSDET: begin
                    ctl.add_det = 1'b1;
                end
                default: begin
                    ctl.add_always = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pac_accumulator.sv
// Phase register, frequency register and registered add carry.
// An accumulator write beats the add; a frequency write lands at the
// edge, so the add in that cycle sees the whole previous word.
module pac_accumulator #(
    parameter int PHS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic             frq_wr,
    input  logic [PHS_W-1:0] frq_wdata,
    input  logic             phs_wr,
    input  logic [PHS_W-1:0] phs_wdata,
    output logic [PHS_W-1:0] phs_q,
    output logic [PHS_W-1:0] frq_q,
    output logic             carry_q
);

    logic [PHS_W:0] sum;

    // Widened add so the carry is the top bit
    always_comb begin
        sum = {1'b0, phs_q} + {1'b0, frq_q};
    end

    // Frequency word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frq_q <= '0;
        end else if (frq_wr) begin
            frq_q <= frq_wdata;
        end
    end

    // Accumulator and one-cycle carry pulse, write has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phs_q   <= '0;
            carry_q <= 1'b0;
        end else if (phs_wr) begin
            phs_q   <= phs_wdata;
            carry_q <= 1'b0;
        end else if (add_en) begin
            phs_q   <= sum[PHS_W-1:0];
            carry_q <= sum[PHS_W];
        end else begin
            carry_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pac_pin_driver.sv
// Places the chosen output value on pin A and, in differential
// modes, its inverse on pin B. Pin A wins if both selects match.
module pac_pin_driver
    import pac_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int SEL_W = 3
) (
    input  ctl_t             ctl,
    input  logic             phs_msb,
    input  logic             carry,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    output logic [NPINS-1:0] pin_drive
);

    logic out_val;
    logic out_on;

    // Select the value source for pin A
    always_comb begin
        out_on  = (ctl.src != SRC_NONE);
        case (ctl.src)
            SRC_MSB:   out_val = phs_msb;
            SRC_CARRY: out_val = carry;
            default:   out_val = 1'b0;
        endcase
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // Per-pin drive: A value, B inverse, otherwise low
        always_comb begin
            if (out_on && (sel_a == SEL_W'(i))) begin
                pin_drive[i] = out_val;
            end else if (out_on && ctl.diff && (sel_b == SEL_W'(i))) begin
                pin_drive[i] = ~out_val;
            end else begin
                pin_drive[i] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/phase_acc_counter.sv
// Top of the mode-selectable phase accumulator counter. Wires the
// pin sampler, mode decoder, accumulator and pin driver together and
// forms the add enable from the decoded gating and sampled pin levels.
module phase_acc_counter
    import pac_pkg::*;
#(
    parameter int PHS_W = 32,
    parameter int NPINS = 8,
    localparam int SEL_W = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       mode,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    input  logic [NPINS-1:0] pins_in,
    input  logic             frq_wr,
    input  logic [PHS_W-1:0] frq_wdata,
    input  logic             phs_wr,
    input  logic [PHS_W-1:0] phs_wdata,
    output logic [NPINS-1:0] pin_drive,
    output logic [PHS_W-1:0] phs_rd
);

    ctl_t             ctl;
    logic             a_lvl;
    logic             b_lvl;
    logic             logic_hit;
    logic             add_en;
    logic [PHS_W-1:0] frq_cur;
    logic             carry_q;

    pac_pin_sampler #(.NPINS(NPINS), .SEL_W(SEL_W)) u_samp (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_in (pins_in),
        .sel_a   (sel_a),
        .sel_b   (sel_b),
        .a_lvl   (a_lvl),
        .b_lvl   (b_lvl)
    );

    pac_mode_decode u_dec (
        .mode (mode),
        .ctl  (ctl)
    );

    // Add enable from the decoded gating rule
    always_comb begin
        logic_hit = ctl.truth[{a_lvl, b_lvl}];
        add_en    = ctl.add_always
                  | (ctl.add_det & a_lvl)
                  | (ctl.add_logic & logic_hit);
    end

    pac_accumulator #(.PHS_W(PHS_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .add_en    (add_en),
        .frq_wr    (frq_wr),
        .frq_wdata (frq_wdata),
        .phs_wr    (phs_wr),
        .phs_wdata (phs_wdata),
        .phs_q     (phs_rd),
        .frq_q     (frq_cur),
        .carry_q   (carry_q)
    );

    pac_pin_driver #(.NPINS(NPINS), .SEL_W(SEL_W)) u_drv (
        .ctl       (ctl),
        .phs_msb   (phs_rd[PHS_W-1]),
        .carry     (carry_q),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .pin_drive (pin_drive)
    );

endmodule

// File: rtl/pac_checker.sv
// Temporal checks for phase_acc_counter, attached by bind below.
module pac_checker #(
    parameter int PHS_W = 32,
    parameter int NPINS = 8,
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       mode,
    input logic [SEL_W-1:0] sel_a,
    input logic [SEL_W-1:0] sel_b,
    input logic             phs_wr,
    input logic [PHS_W-1:0] phs_wdata,
    input logic [NPINS-1:0] pin_drive,
    input logic [PHS_W-1:0] phs_rd,
    input logic [PHS_W-1:0] frq_cur,
    input logic             a_lvl
);

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 5'b00000 && !phs_wr) |=> phs_rd == $past(phs_rd)); // R1

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 5'b00000) |-> pin_drive == '0); // R1

    AST_NCO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 5'b00100 || mode == 5'b00101) && !phs_wr)
        |=> phs_rd == PHS_W'($past(phs_rd) + $past(frq_cur))); // R2

    AST_NCO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 5'b00100) |-> pin_drive[sel_a] == phs_rd[PHS_W-1]); // R2

    AST_DET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 5'b01000 && !phs_wr && !a_lvl) |=> phs_rd == $past(phs_rd)); // R5

    AST_DIFF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 5'b00101 || mode == 5'b00111) && sel_a != sel_b)
        |-> pin_drive[sel_b] != pin_drive[sel_a]); // R7

    AST_DRIVE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pin_drive) <= 1 || mode == 5'b00101 || mode == 5'b00111); // R7

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        phs_wr |=> phs_rd == $past(phs_wdata)); // R9

endmodule

bind phase_acc_counter pac_checker #(
    .PHS_W(PHS_W), .NPINS(NPINS), .SEL_W(SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .phs_wr    (phs_wr),
    .phs_wdata (phs_wdata),
    .pin_drive (pin_drive),
    .phs_rd    (phs_rd),
    .frq_cur   (frq_cur),
    .a_lvl     (a_lvl)
);

// File: tb/phase_acc_counter_test.sv
// Bench: behavioural reference model compared every clock, plus
// directed checks on latency, write ordering and pulse spacing.
module phase_acc_counter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode = 5'b0;
    logic [2:0]  sel_a = 3'd2;
    logic [2:0]  sel_b = 3'd5;
    logic [7:0]  pins_in = 8'h00;
    logic        frq_wr = 1'b0;
    logic [31:0] frq_wdata = '0;
    logic        phs_wr = 1'b0;
    logic [31:0] phs_wdata = '0;
    logic [7:0]  pin_drive;
    logic [31:0] phs_rd;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    logic [7:0]  m_pin;
    logic [31:0] m_frq;
    logic [31:0] m_phs;
    bit          m_carry;

    always #5 clk = ~clk;

    phase_acc_counter uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .sel_a(sel_a), .sel_b(sel_b),
        .pins_in(pins_in), .frq_wr(frq_wr), .frq_wdata(frq_wdata),
        .phs_wr(phs_wr), .phs_wdata(phs_wdata),
        .pin_drive(pin_drive), .phs_rd(phs_rd)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model: step on each edge from the values seen before it
    always @(posedge clk) begin
        bit a, b, add;
        logic [32:0] s;
        if (!rst_n) begin
            m_pin = '0; m_frq = '0; m_phs = '0; m_carry = 0;
        end else begin
            a = m_pin[sel_a];
            b = m_pin[sel_b];
            if (mode[4]) add = mode[{a, b}];
            else if (mode inside {5'b00100, 5'b00101, 5'b00110, 5'b00111}) add = 1;
            else if (mode == 5'b01000) add = a;
            else add = 0;
            s = m_phs + {1'b0, m_frq};
            if (phs_wr) begin m_phs = phs_wdata; m_carry = 0; end
            else if (add) begin m_phs = s[31:0]; m_carry = s[32]; end
            else m_carry = 0;
            if (frq_wr) m_frq = frq_wdata;
            m_pin = pins_in;
        end
    end

    function automatic logic [7:0] exp_drive();
        logic [7:0] d = '0;
        bit v;
        if (mode == 5'b00100 || mode == 5'b00101) v = m_phs[31];
        else if (mode == 5'b00110 || mode == 5'b00111) v = m_carry;
        else return d;
        if (mode[0]) d[sel_b] = ~v;
        d[sel_a] = v;
        return d;
    endfunction

    // Compare against the model away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(cur_req, "phs", phs_rd, m_phs);
            check(cur_req, "drive", {24'b0, pin_drive}, {24'b0, exp_drive()});
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int pos_last;
        int pulses;
        tick(1);
        cmp_on = 1'b1;
        tick(2);
        cur_req = "R1";
        check("R1", "reset phs", phs_rd, 32'h0);
        check("R1", "reset drive", {24'b0, pin_drive}, 32'h0);
        rst_n = 1'b1;

        // R1 / R9: write while off, then hold
        phs_wr = 1; phs_wdata = 32'h0000_007B; frq_wr = 1; frq_wdata = 32'h0000_0011;
        tick(1);
        phs_wr = 0; frq_wr = 0;
        tick(5);
        check("R1", "off hold", phs_rd, 32'h0000_007B);
        check("R1", "off pins", {24'b0, pin_drive}, 32'h0);

        // R2 oscillator, then R7 differential
        cur_req = "R2";
        mode = 5'b00100; frq_wr = 1; frq_wdata = 32'h1000_0000;
        tick(1); frq_wr = 0;
        tick(20);
        cur_req = "R7";
        mode = 5'b00101;
        tick(20);
        sel_b = 3'd2;
        tick(8);
        check("R7", "same select A wins", {31'b0, pin_drive[2]}, {31'b0, phs_rd[31]});
        sel_b = 3'd5;

        // R8: frequency write during an add
        cur_req = "R8";
        mode = 5'b00100;
        frq_wr = 1; frq_wdata = 32'd5; phs_wr = 1; phs_wdata = 32'd0;
        tick(1);
        phs_wr = 0; frq_wdata = 32'd100;
        tick(1);
        frq_wr = 0;
        check("R8", "old word used", phs_rd, 32'd5);
        tick(1);
        check("R8", "new word next", phs_rd, 32'd105);

        // R9: accumulator write during an add
        cur_req = "R9";
        phs_wr = 1; phs_wdata = 32'hDEAD_0000;
        tick(1); phs_wr = 0;
        check("R9", "write wins", phs_rd, 32'hDEAD_0000);

        // R3 / R4: pulse spacing at 2^30
        cur_req = "R4";
        mode = 5'b00110;
        frq_wr = 1; frq_wdata = 32'h4000_0000; phs_wr = 1; phs_wdata = 32'd0;
        tick(1);
        frq_wr = 0; phs_wr = 0;
        pulses = 0; pos_last = -1;
        for (int k = 2; k < 18; k++) begin
            tick(1);
            if (pin_drive[2]) begin
                pulses++;
                if (pos_last < 0) check("R4", "first pulse edge", k, 5);
                else check("R3", "pulse spacing", k - pos_last, 4);
                pos_last = k;
            end
        end
        check("R4", "pulse count", pulses, 4);
        cur_req = "R7";
        mode = 5'b00111;
        tick(12);

        // R5 / R10: positive detector
        cur_req = "R5";
        mode = 5'b01000;
        frq_wr = 1; frq_wdata = 32'd1; phs_wr = 1; phs_wdata = 32'd0;
        pins_in = 8'h04;
        tick(1);
        frq_wr = 0; phs_wr = 0;
        tick(3);
        pins_in = 8'h00;
        tick(4);
        check("R5", "four adds", phs_rd, 32'd4);
        check("R5", "no drive", {24'b0, pin_drive}, 32'h0);
        cur_req = "R10";
        pins_in = 8'h04;
        tick(1);
        check("R10", "one edge later", phs_rd, 32'd4);
        tick(1);
        check("R10", "two edges later", phs_rd, 32'd5);
        pins_in = 8'h00;
        tick(3);

        // R6: A AND B
        cur_req = "R6";
        mode = 5'b11000;
        phs_wr = 1; phs_wdata = 32'd0; pins_in = 8'h04;
        tick(1); phs_wr = 0;
        tick(2);
        check("R6", "A only no add", phs_rd, 32'd0);
        pins_in = 8'h24;
        tick(1);
        pins_in = 8'h00;
        tick(2);
        check("R6", "A and B one add", phs_rd, 32'd1);

        // R6: sweep every truth table over every pin pair
        for (int tt = 0; tt < 16; tt++) begin
            mode = {1'b1, 4'(tt)};
            for (int ab = 0; ab < 4; ab++) begin
                pins_in = 8'h00;
                pins_in[2] = ab[1];
                pins_in[5] = ab[0];
                pins_in[0] = ab[0];
                tick(1);
            end
        end
        pins_in = 8'h00;
        tick(3);

        // R1: unlisted codes behave as disabled
        cur_req = "R1";
        mode = 5'b01101;
        pins_in = 8'hFF;
        tick(6);
        mode = 5'b00010;
        tick(4);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule